// File: doc/BRIEF.md
# Single-Bit Aggregate Flag Unit

This block joins a fixed group of processor ports in one collective step on single-bit flags. Each port raises its request line, presents one flag bit and an operation code, and holds all three. The unit waits until every port is requesting. In that cycle it captures all flags and codes together, works out one collective answer, and on the next cycle presents the answer with a one-cycle completion pulse. The pulse releases every port at once.

Six collective operations are offered. The unit can return the raw per-port flag word, a logical OR, a logical AND, the lowest port index holding a set flag, the number of set flags, or a coarse quantity code. The quantity code tells apart none, exactly one, several and every port. The answer goes to all ports on one shared result bus. If the ports disagree on the operation code, an error bit goes out with the pulse, and the code from port 0 decides the answer.

Top module: `flag_gather_unit`

## Requirements
- R1: `done_o` is high only in the cycle after one in which every bit of `req_i` was high and `done_o` was low; while any port is not requesting, no completion occurs.
- R2: `done_o` is a single-cycle pulse. `req_i` is ignored in the cycle `done_o` is high. `result_o` changes only in a cycle where `done_o` is high.
- R3: Opcode 0 (mask): bit k of `result_o` equals the flag of port k. Bits above NPORT-1 are zero.
- R4: Opcode 1 (any) returns 1 when at least one flag is set, else 0. Opcode 2 (all) returns 1 only when every flag is set.
- R5: Opcode 3 (first) returns the index of the lowest-numbered port whose flag is set, or NPORT when none is set.
- R6: Opcode 4 (count) returns the number of set flags, from 0 to NPORT.
- R7: Opcode 5 (quantity) returns 0 for no set flags, 1 for exactly one, NPORT when all are set, and 2 otherwise.
- R8: If any port's 3-bit opcode slice (port k at bits 3k+2..3k of `op_i`) differs from port 0's, `err_o` is high with `done_o` and the result follows port 0's opcode. `err_o` is never high without `done_o`.
- R9: A new operation whose requests are all high in the cycle after the `done_o` cycle completes with `done_o` two cycles after the previous pulse.
- R10: After reset, `done_o`, `err_o` and `result_o` are zero. Opcodes 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NPORT | Per-port request, held until the completion pulse |
| flag_i | input | NPORT | Per-port flag bit |
| op_i | input | 3*NPORT | Per-port opcode, port k in slice 3k+2..3k |
| done_o | output | 1 | One-cycle completion pulse releasing all ports |
| result_o | output | max(NPORT, clog2(NPORT+1)) | Collective answer |
| err_o | output | 1 | Opcode disagreement, valid with `done_o` |

## Verification
Two cases are hard to reach from the ports. The first is a partial arrival, where some ports have requested and the rest have not. The bench raises requests one port per cycle and checks at each step that no pulse appears too early. The second is opcode disagreement, which never happens in a well-behaved system. The bench drives differing slices on purpose and checks that the answer follows port 0. Every flag pattern is swept under every opcode, and the operations run back to back so the turnaround cycle is also checked.

// File: rtl/fgu_pkg.sv
package fgu_pkg;
   localparam int OPW = 3;

   typedef enum logic [OPW-1:0] {
      FOP_MASK  = 3'd0,
      FOP_ANY   = 3'd1,
      FOP_ALL   = 3'd2,
      FOP_FIRST = 3'd3,
      FOP_COUNT = 3'd4,
      FOP_QUANT = 3'd5
   } fop_e;

   function automatic int res_width(input int nport);
      int cw;
      cw = $clog2(nport + 1);
      return (nport > cw) ? nport : cw;
   endfunction
endpackage

// File: rtl/fgu_gather.sv
module fgu_gather
   import fgu_pkg::*;
#(
   parameter int NPORT = 4
) (
   input  logic [NPORT-1:0]     req_i,
   input  logic [NPORT*OPW-1:0] op_i,
   input  logic                 busy_i,
   output logic                 fire_o,
   output logic [OPW-1:0]       op0_o,
   output logic                 mismatch_o
);
   logic [NPORT-1:0] differs;

   assign op0_o     = op_i[OPW-1:0];
   assign differs[0] = 1'b0;

   for (genvar k = 1; k < NPORT; k++) begin : g_cmp
      assign differs[k] = (op_i[k*OPW +: OPW] != op_i[OPW-1:0]);
   end

   // the pulse cycle closes the handshake, so requests there do not count
   assign fire_o     = (&req_i) & ~busy_i;
   assign mismatch_o = |differs;
endmodule

// File: rtl/fgu_encode.sv
module fgu_encode
   import fgu_pkg::*;
#(
   parameter int NPORT = 4,
   parameter int RESW  = res_width(NPORT)
) (
   input  logic [NPORT-1:0] flag_i,
   input  logic [OPW-1:0]   op_i,
   output logic [RESW-1:0]  res_o
);
   localparam int CNTW = $clog2(NPORT + 1);

   logic [CNTW-1:0] pop;
   logic [CNTW-1:0] lowest;
   logic [RESW-1:0] quant;

   always_comb begin
      pop = '0;
      for (int k = 0; k < NPORT; k++) begin
         pop = pop + CNTW'(flag_i[k]);
      end
   end

   always_comb begin
      lowest = CNTW'(NPORT);
      for (int k = NPORT - 1; k >= 0; k--) begin
         if (flag_i[k]) lowest = CNTW'(k);
      end
   end

   always_comb begin
      if (pop == '0)                  quant = RESW'(0);
      else if (pop == CNTW'(1))       quant = RESW'(1);
      else if (pop == CNTW'(NPORT))   quant = RESW'(NPORT);
      else                            quant = RESW'(2);
   end

   always_comb begin
      unique case (op_i)
         FOP_MASK:  res_o = RESW'(flag_i);
         FOP_ANY:   res_o = RESW'(|flag_i);
         FOP_ALL:   res_o = RESW'(&flag_i);
         FOP_FIRST: res_o = RESW'(lowest);
         FOP_COUNT: res_o = RESW'(pop);
         FOP_QUANT: res_o = quant;
         default:   res_o = '0;
      endcase
   end

   always_comb begin
      p_count_bound_r6: assert (pop <= CNTW'(NPORT));
      p_first_hits_set_r5: assert (lowest == CNTW'(NPORT) || flag_i[lowest[$clog2(NPORT)-1:0]]);
   end
endmodule

// File: rtl/flag_gather_unit.sv
module flag_gather_unit
   import fgu_pkg::*;
#(
   parameter int NPORT = 4,
   localparam int RESW = res_width(NPORT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPORT-1:0]     req_i,
   input  logic [NPORT-1:0]     flag_i,
   input  logic [NPORT*OPW-1:0] op_i,
   output logic                 done_o,
   output logic [RESW-1:0]      result_o,
   output logic                 err_o
);
   if (NPORT < 2 || NPORT > 16) begin : g_bad_nport
      $error("flag_gather_unit: NPORT must lie in 2..16");
   end

   logic            fire;
   logic [OPW-1:0]  op0;
   logic            mismatch;
   logic [RESW-1:0] enc;

   fgu_gather #(.NPORT(NPORT)) u_gather (
      .req_i      (req_i),
      .op_i       (op_i),
      .busy_i     (done_o),
      .fire_o     (fire),
      .op0_o      (op0),
      .mismatch_o (mismatch)
   );

   fgu_encode #(.NPORT(NPORT), .RESW(RESW)) u_encode (
      .flag_i (flag_i),
      .op_i   (op0),
      .res_o  (enc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         err_o    <= 1'b0;
         result_o <= '0;
      end else begin
         done_o <= fire;
         err_o  <= fire & mismatch;
         if (fire) result_o <= enc;
      end
   end

   p_done_needs_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(&req_i) && !$past(done_o)));
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_result_moves_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (result_o != $past(result_o)) |-> done_o);
   p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);
endmodule

// File: tb/flag_gather_unit_bench.sv
module flag_gather_unit_bench;
   import fgu_pkg::*;
   localparam int NP = 4;
   localparam int RW = res_width(NP);
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0] req = '0;
   logic [NP-1:0] flg = '0;
   logic [NP*OPW-1:0] ops = '0;
   logic done;
   logic [RW-1:0] res;
   logic err;
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flag_gather_unit #(.NPORT(NP)) u_flag_gather_unit (
      .clk(clk), .rst_n(rst_n), .req_i(req), .flag_i(flg), .op_i(ops),
      .done_o(done), .result_o(res), .err_o(err)
   );

   function automatic int model(input int f, input int op);
      int c = 0, lo = NP;
      for (int k = NP - 1; k >= 0; k--) if ((f >> k) & 1) begin c++; lo = k; end
      case (op)
         0: return f;
         1: return (c > 0) ? 1 : 0;
         2: return (c == NP) ? 1 : 0;
         3: return lo;
         4: return c;
         5: return (c == 0) ? 0 : (c == 1) ? 1 : (c == NP) ? NP : 2;
         default: return 0;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // drives one operation; the pulse cycle is sampled at the following negedge
   task automatic run_op(input int f, input logic [OPW-1:0] op, input string tag);
      @(negedge clk);
      req = '1; flg = NP'(f); ops = {NP{op}};
      @(negedge clk);
      check({tag, " done"}, int'(done), 1);
      check({tag, " result"}, int'(res), model(f, int'(op)));
      check({tag, " err"}, int'(err), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset done", int'(done), 0);
      check("R10 reset result", int'(res), 0);
      check("R10 reset err", int'(err), 0);
      rst_n = 1'b1;

      // back-to-back sweep of every flag pattern under every opcode (R3-R7, R9, R10)
      for (int op = 0; op < 8; op++) begin
         for (int f = 0; f < (1 << NP); f++) begin
            case (op)
               0: run_op(f, 3'(op), "R3 mask");
               1, 2: run_op(f, 3'(op), "R4 any/all");
               3: run_op(f, 3'(op), "R5 first");
               4: run_op(f, 3'(op), "R6 count");
               5: run_op(f, 3'(op), "R7 quant");
               default: run_op(f, 3'(op), "R10 unused op");
            endcase
         end
      end
      check("R9 back-to-back done count", total, 3 + 8 * 16 * 3);

      // pulse lasts one cycle; requests kept high in the pulse cycle are ignored (R2)
      run_op(5, 3'd4, "R2 setup");
      @(negedge clk);
      check("R2 single pulse", int'(done), 0);
      check("R2 result held", int'(res), 2);
      req = '0;
      @(negedge clk);
      check("R2 idle", int'(done), 0);

      // staggered arrival: no completion until the last port (R1)
      flg = 4'b0110; ops = {NP{3'd3}};
      for (int k = 0; k < NP; k++) begin
         req[k] = 1'b1;
         @(negedge clk);
         if (k < NP - 1) check("R1 early done", int'(done), 0);
         else begin
            check("R1 done after last", int'(done), 1);
            check("R1 result", int'(res), 1);
         end
      end
      req = '0;
      @(negedge clk);

      // opcode disagreement: port 0 says count, port 2 says any (R8)
      req = '1; flg = 4'b1011;
      ops = {3'd4, 3'd1, 3'd4, 3'd4};
      @(negedge clk);
      check("R8 err", int'(err), 1);
      check("R8 port0 op wins", int'(res), 3);
      check("R8 done", int'(done), 1);
      req = '0;
      @(negedge clk);
      check("R8 err clears", int'(err), 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog R1 act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule